// File: doc/BRIEF.md
# Instruction Loop Buffer

This block sits in the instruction fetch stage. It keeps the most recently fetched instruction words as one unbroken run of consecutive word addresses, the window. It also reads a few words past the address the fetch stage asked for last. A fetch request that lands inside the window is answered from local storage and costs no memory access. A request outside the window throws the window away, restarts it at the requested address and stalls the fetch stage until that word has come back from memory.

Addresses count instruction words. The window is held as a base address and a count of valid words. Storage slots are picked by the low address bits, so the depth is a power of two of at least 4, and the lookahead distance is at most depth minus two. The memory read port takes one request per cycle and returns the words in request order after a fixed latency. Requests on the fetch side use valid/ready and must stay stable while they are stalled.

Top module: `loop_buffer`

## Requirements
- R1: After reset, and until the first fetch request, the block drives no instruction output (`instValid` = 0) and issues no memory read (`memReqValid` = 0).
- R2: A request whose address is inside the window is accepted in the cycle it is presented (`reqReady` = 1). The block returns the word held for that address and issues no memory read for it.
- R3: The window is the address range base <= address < base + count, at most DEPTH words long. Any other address misses, and so does every address while the window is empty, for example right after reset.
- R4: Memory reads go out for consecutive addresses at no more than one per cycle. They continue until the block has asked for the last accepted (or restarted) address plus AHEAD, and go no further than that.
- R5: A request with `reqBranch` = 1 that misses empties the window and restarts it at the target. The target read is issued in the next cycle. The request stays unaccepted until the target word has been stored, which with a memory latency of L cycles means L+2 unaccepted clock edges.
- R6: A missing request with `reqBranch` = 0 whose address has already been requested and is still in flight just waits for that word, with no new read. The same request with `reqBranch` = 1 restarts and reads the target again.
- R7: Read responses still in flight when the window restarts are discarded, and every delivered word belongs to the address delivered with it.
- R8: When the window already holds DEPTH words and another word arrives, the oldest word is dropped and the base moves up by one. A later request to the dropped address misses.
- R9: A loop of at most DEPTH-AHEAD words is read from memory only during its first pass. Later passes are served with no stall and no memory read.
- R10: A forward branch to an address a few words past the current one, already in the window, is served with no stall and no new read.
- R11: Exactly one cycle after each accepted request, `instValid` is high with `instAddr` equal to the accepted address. In every other cycle `instValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Fetch request present |
| reqAddr | input | ADDR_W | Word address requested |
| reqBranch | input | 1 | 1: request is a taken-branch target; 0: sequential |
| reqReady | output | 1 | Request accepted this cycle (address is in the window) |
| instValid | output | 1 | Instruction word valid |
| instAddr | output | ADDR_W | Address of the delivered word |
| instData | output | DATA_W | Delivered instruction word |
| memReqValid | output | 1 | Memory read request |
| memReqAddr | output | ADDR_W | Memory read address |
| memRespValid | input | 1 | Memory read data valid, in request order |
| memRespData | input | DATA_W | Memory read data |

## Verification
Two functions can land in the same cycle. One is a window restart. The other is the arrival of a response that was requested for the old window. The bench brings the two together by branching out of the window, or onto a word that is still in flight, while prefetch reads are outstanding. Each case is judged three ways: the delivered data must match the memory contents of the delivered address, the stall length must be exactly the latency plus two, and the read log must show the target read afresh. A second overlap is a hit to the oldest word in the same cycle that a new arrival overwrites its slot. Long sequential runs followed by a branch back to the low end of a full window provoke this, and the scoreboard judges it.

// File: rtl/lb_pkg.sv
package lb_pkg;

  typedef struct packed {
    logic accept;
    logic flush;
    logic issue;
  } lbStrobe_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } lbState_e;

endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import lb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqBranch,
  input  logic      hit,
  input  logic      inFlight,
  input  logic      issueOk,
  output lbStrobe_t strb,
  output logic      reqReady
);

  lbState_e stateQ, stateD;
  logic     missNew;

  always_comb begin
    strb     = '0;
    reqReady = hit;
    // a stall is opened only once; the held request is then just waited on
    missNew     = reqValid && !hit && (stateQ == ST_RUN);
    strb.accept = reqValid && hit;
    strb.flush  = missNew && (reqBranch || !inFlight);
    strb.issue  = issueOk && !strb.flush;

    stateD = stateQ;
    unique case (stateQ)
      ST_RUN:  if (missNew) stateD = ST_WAIT;
      ST_WAIT: if (strb.accept) stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/lb_dpath.sv
module lb_dpath
  import lb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int AHEAD  = 2,
  parameter int DROP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData,
  output logic              hit,
  output logic              inFlight,
  output logic              issueOk,
  output logic [ADDR_W-1:0] issueAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] AHEAD_A = ADDR_W'(AHEAD);
  localparam logic [CNT_W-1:0]  FULL_C  = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] baseQ, issueQ, curQ;
  logic [CNT_W-1:0]  countQ, pendQ;
  logic [DROP_W-1:0] dropQ;
  logic              liveQ;
  logic [DATA_W-1:0] slotQ [DEPTH];

  logic [ADDR_W-1:0] tailAddr, winOff, flyOff, gap;
  logic              respUse, respDrop, bufFull;
  logic [IDX_W-1:0]  wrIdx, rdIdx;

  // window geometry: all offsets are modulo 2**ADDR_W
  assign tailAddr = baseQ + ADDR_W'(countQ);
  assign winOff   = reqAddr - baseQ;
  assign flyOff   = reqAddr - tailAddr;
  assign gap      = issueQ - curQ;

  assign hit      = (countQ != '0) && (winOff < ADDR_W'(countQ));
  assign inFlight = flyOff < ADDR_W'(pendQ);
  assign issueOk  = liveQ && (gap <= AHEAD_A);
  assign bufFull  = (countQ == FULL_C);
  assign issueAddr = issueQ;

  assign respUse  = memRespValid && (dropQ == '0) && !strb.flush;
  assign respDrop = memRespValid && (dropQ != '0) && !strb.flush;
  assign wrIdx    = tailAddr[IDX_W-1:0];
  assign rdIdx    = reqAddr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      issueQ <= '0;
      curQ   <= '0;
      countQ <= '0;
      pendQ  <= '0;
      dropQ  <= '0;
      liveQ  <= 1'b0;
    end else if (strb.flush) begin
      baseQ  <= reqAddr;
      issueQ <= reqAddr;
      curQ   <= reqAddr;
      countQ <= '0;
      pendQ  <= '0;
      // every read still outstanding belongs to the old window
      dropQ  <= dropQ + DROP_W'(pendQ) - DROP_W'(memRespValid);
      liveQ  <= 1'b1;
    end else begin
      if (strb.issue)  issueQ <= issueQ + ADDR_W'(1);
      if (strb.accept) curQ   <= reqAddr;
      if (respDrop)    dropQ  <= dropQ - DROP_W'(1);
      pendQ <= pendQ + CNT_W'(strb.issue) - CNT_W'(respUse);
      if (respUse) begin
        if (bufFull) baseQ  <= baseQ + ADDR_W'(1);
        else         countQ <= countQ + CNT_W'(1);
      end
    end
  end

  // storage: slot chosen by low address bits; a full window overwrites its oldest word
  always_ff @(posedge clk) begin
    if (respUse) slotQ[wrIdx] <= memRespData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outAddr  <= '0;
      outData  <= '0;
    end else begin
      outValid <= strb.accept;
      if (strb.accept) begin
        outAddr <= reqAddr;
        outData <= slotQ[rdIdx];
      end
    end
  end

endmodule

// File: rtl/loop_buffer.sv
module loop_buffer
  import lb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int AHEAD  = 2,
  parameter int DROP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqBranch,
  output logic              reqReady,
  output logic              instValid,
  output logic [ADDR_W-1:0] instAddr,
  output logic [DATA_W-1:0] instData,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);

  lbStrobe_t strb;
  logic      hit, inFlight, issueOk;
  logic      flushStb;

  lb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBranch(reqBranch),
    .hit      (hit),
    .inFlight (inFlight),
    .issueOk  (issueOk),
    .strb     (strb),
    .reqReady (reqReady)
  );

  lb_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .AHEAD (AHEAD),
    .DROP_W(DROP_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqAddr     (reqAddr),
    .memRespValid(memRespValid),
    .memRespData (memRespData),
    .hit         (hit),
    .inFlight    (inFlight),
    .issueOk     (issueOk),
    .issueAddr   (memReqAddr),
    .outValid    (instValid),
    .outAddr     (instAddr),
    .outData     (instData)
  );

  assign memReqValid = strb.issue;
  assign flushStb    = strb.flush;

endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              instValid,
  input logic [ADDR_W-1:0] instAddr,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              flushStb
);

  logic              seenQ;
  logic [ADDR_W-1:0] lastIssQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenQ    <= 1'b0;
      lastIssQ <= '0;
    end else if (memReqValid) begin
      seenQ    <= 1'b1;
      lastIssQ <= memReqAddr;
    end
  end

  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!instValid && !memReqValid)
        else $error("reset outputs active");
    end
  end

  p_out_follows_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (instValid && instAddr == $past(reqAddr)));

  p_no_spurious_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !instValid);

  p_flush_blocks_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> !reqReady);

  p_target_read_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    flushStb |=> (memReqValid && memReqAddr == $past(reqAddr)));

  p_prefetch_in_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && seenQ && !$past(flushStb)) |-> (memReqAddr == lastIssQ + ADDR_W'(1)));

endmodule

bind loop_buffer lb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqAddr    (reqAddr),
  .reqReady   (reqReady),
  .instValid  (instValid),
  .instAddr   (instAddr),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .flushStb   (flushStb)
);

// File: tb/sim_loop_buffer.sv
`timescale 1ns/1ps
module sim_loop_buffer;

  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqBranch = 1'b0;
  logic          reqReady;
  logic          instValid;
  logic [AW-1:0] instAddr;
  logic [DW-1:0] instData;
  logic          memReqValid;
  logic [AW-1:0] memReqAddr;
  logic          memRespValid;
  logic [DW-1:0] memRespData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [AW-1:0] expQ[$];
  logic [AW-1:0] readLog[$];
  logic          pipeV [LAT];
  logic [AW-1:0] pipeA [LAT];

  always #2.5 clk = ~clk;

  loop_buffer u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqBranch(reqBranch), .reqReady(reqReady),
    .instValid(instValid), .instAddr(instAddr), .instData(instData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  function automatic logic [DW-1:0] memWord(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic int readsOf(input logic [AW-1:0] a);
    int n = 0;
    foreach (readLog[i]) if (readLog[i] == a) n++;
    return n;
  endfunction

  // memory model: fixed latency, in-order, one request per cycle
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LAT; i++) pipeV[i] <= 1'b0;
    end else begin
      if (memReqValid) readLog.push_back(memReqAddr);
      pipeV[0] <= memReqValid;
      pipeA[0] <= memReqAddr;
      for (int i = 1; i < LAT; i++) begin
        pipeV[i] <= pipeV[i-1];
        pipeA[i] <= pipeA[i-1];
      end
    end
  end
  assign memRespValid = pipeV[LAT-1];
  assign memRespData  = memWord(pipeA[LAT-1]);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor (R2, R7, R11)
  always @(negedge clk) begin
    if (rstN && instValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11", "output without request", instAddr, -1);
      end else begin
        logic [AW-1:0] e;
        e = expQ.pop_front();
        check(instAddr == e, "R11", "delivered address", instAddr, e);
        check(instData == memWord(e), "R2/R7", "delivered data", instData, memWord(e));
      end
    end
  end

  task automatic fetch(input logic [AW-1:0] a, input logic br, output int stalls);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = a;
    reqBranch = br;
    expQ.push_back(a);
    stalls = 0;
    #1;
    while (!reqReady) begin
      stalls++;
      if (stalls > 500) begin
        check(1'b0, "R5", "request never accepted", stalls, 0);
        break;
      end
      @(posedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int s, sum, mark;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: quiet after reset; R3: empty window misses
    @(negedge clk);
    check(!instValid && !memReqValid, "R1", "outputs idle after reset", instValid, 0);
    reqValid = 1'b1; reqAddr = 32'd100; reqBranch = 1'b1;
    #1;
    check(!reqReady, "R3", "empty window hit", reqReady, 0);
    reqValid = 1'b0;
    idle(3);
    check(readLog.size() == 0, "R1", "reads before first request", readLog.size(), 0);

    // R5, R4: cold branch, then loop passes R9
    mark = readLog.size();
    fetch(32'd100, 1'b1, s);
    check(s == LAT + 2, "R5", "cold branch stall", s, LAT + 2);
    check(readLog[mark] == 100 && readLog[mark+1] == 101 && readLog[mark+2] == 102,
          "R4", "consecutive prefetch", readLog[mark+2], 102);
    for (int a = 101; a <= 105; a++) fetch(a, 1'b0, s);
    sum = 0;
    fetch(32'd100, 1'b1, s); sum += s;
    for (int a = 101; a <= 105; a++) begin fetch(a, 1'b0, s); sum += s; end
    check(sum == 0, "R9", "second pass stalls", sum, 0);
    idle(8);
    mark = readLog.size();
    sum = 0;
    fetch(32'd100, 1'b1, s); sum += s;
    for (int a = 101; a <= 105; a++) begin fetch(a, 1'b0, s); sum += s; end
    idle(8);
    check(sum == 0, "R9", "third pass stalls", sum, 0);
    check(readLog.size() == mark, "R9", "reads in later pass", readLog.size() - mark, 0);

    // R10: short forward branch; R4: lookahead limit
    fetch(32'd500, 1'b1, s);
    fetch(32'd501, 1'b0, s);
    fetch(32'd502, 1'b0, s);
    idle(8);
    check(readsOf(32'd505) == 0, "R4", "read beyond lookahead", readsOf(32'd505), 0);
    fetch(32'd504, 1'b1, s);
    check(s == 0, "R10", "forward branch stall", s, 0);
    check(readsOf(32'd504) == 1, "R10", "forward branch reads", readsOf(32'd504), 1);

    // R6: in-flight target, sequential waits, branch restarts (R7 via scoreboard)
    fetch(32'd600, 1'b1, s);
    fetch(32'd602, 1'b0, s);
    check(s > 0 && s < LAT + 2, "R6", "sequential in-flight stall", s, 1);
    check(readsOf(32'd602) == 1, "R6", "sequential in-flight reads", readsOf(32'd602), 1);
    fetch(32'd700, 1'b1, s);
    fetch(32'd702, 1'b1, s);
    check(s == LAT + 2, "R6", "branch in-flight stall", s, LAT + 2);
    check(readsOf(32'd702) == 2, "R6", "branch in-flight reads", readsOf(32'd702), 2);

    // R8: full window drops oldest
    fetch(32'd400, 1'b1, s);
    for (int a = 401; a <= 420; a++) fetch(a, 1'b0, s);
    fetch(32'd415, 1'b1, s);
    check(s == 0, "R8", "recent word kept", s, 0);
    fetch(32'd400, 1'b1, s);
    check(s == LAT + 2, "R8", "dropped word misses", s, LAT + 2);

    idle(10);
    check(expQ.size() == 0, "R11", "outputs missing", expQ.size(), 0);
    summary();
  end

endmodule